// File: doc/BRIEF.md
# Eye Opening Monitor Sweep Controller

This block drives an eye-diagram scan of a serial receiver. It steps a sampling-phase code and a voltage-offset code over a full grid. The voltage code runs through its whole range for each phase before the phase moves on. At every grid point it waits a programmable number of settle cycles so the analog settings can stabilise. It then counts, over a fixed dwell window, the cycles on which the offset comparator's bit disagrees with the main comparator's bit.

Each finished point is emitted on a valid/ready result port with its phase code, its voltage code and its hit count. The scan holds while a result waits to be taken. A start command begins a scan when the block is idle. Busy is high for the whole scan, and a single-cycle done pulse follows the acceptance of the last point. The analog comparators, the offset DAC and the phase interpolator sit outside this block. They appear here only as code outputs and sampled bit inputs.

Top module: `eye_scan_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and res_valid_o are 0 and phase_code_o and volt_code_o are 0.
- R2: A start_i pulse in idle begins a scan at phase 0, voltage 0, and busy_o is 1 from the cycle after that start until the scan ends.
- R3: Points are visited in phase-outer, voltage-inner order: voltage counts 0 to 2^VOLT_W-1, then phase increments and voltage returns to 0. The code outputs hold the current point's coordinates, and each result carries them in res_phase_o and res_volt_o. With the defaults the grid is 64 by 64, 4096 points.
- R4: Each point discards exactly S settle cycles after its codes are applied and then observes exactly D dwell cycles. S and D are the settle_len_i and dwell_len_i values captured by the start that began the scan, and later changes of these inputs have no effect. res_valid_o rises in the cycle after the S+D-th clock edge counted from the point's start edge.
- R5: The hit count of a point equals the number of dwell cycles on which main_bit_i differs from offs_bit_i. Mismatches during settle cycles or while a result waits are not counted.
- R6: The hit count saturates at 2^CNT_W-1 and does not wrap.
- R7: While res_valid_o is 1 and res_ready_i is 0, the result and the code outputs hold steady. The next point begins on the clock edge where both are 1.
- R8: A start_i pulse while busy_o is 1 is ignored, and the scan order and codes continue unchanged.
- R9: done_o is 1 for exactly one cycle: the cycle after the last point's result is accepted. In that cycle busy_o is already 0.
- R10: With S = 0, counting begins on the first clock edge after the codes change, with no discarded cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a scan when idle |
| settle_len_i | input | SETTLE_W | Settle cycles discarded per point |
| dwell_len_i | input | DWELL_W | Counted cycles per point (0 acts as 1) |
| main_bit_i | input | 1 | Main comparator decision |
| offs_bit_i | input | 1 | Offset comparator decision |
| phase_code_o | output | PHASE_W | Sampling phase code to the front end |
| volt_code_o | output | VOLT_W | Voltage offset code to the front end |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result accepted when high with valid |
| res_phase_o | output | PHASE_W | Phase coordinate of the result |
| res_volt_o | output | VOLT_W | Voltage coordinate of the result |
| res_hits_o | output | CNT_W | Saturated mismatch count of the result |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan end |

## Verification
Each point starts on a clock edge: either the start edge or the edge that accepts the previous result. Edges 1 to S after it are discarded, and edges S+1 to S+D are counted. res_valid_o is due in the cycle after edge S+D, and done_o is due in the cycle after the final acceptance edge. The bench drives inputs 1 ns after each rising edge and numbers the edges since the point's start edge itself. From that number it predicts valid, code and tally values for the following cycle. Results and done are sampled on the falling edge, where the ready value just driven and the design's outputs are both settled.

// File: rtl/eye_scan_pkg.sv
// Shared types for the eye scan controller.
package eye_scan_pkg;

    // Phases of one grid point: idle, settle wait, counting, result held.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_COUNT  = 2'd2,
        ST_EMIT   = 2'd3
    } scan_state_e;

endpackage

// File: rtl/eye_grid_stepper.sv
// Grid coordinate generator.
// Holds the phase and voltage codes. The voltage is the inner index; it
// wraps to zero and carries into the phase. Assumes clear_i and step_i are
// never high together.
module eye_grid_stepper #(
    parameter int PHASE_W = 6,
    parameter int VOLT_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               step_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [VOLT_W-1:0]  volt_o,
    output logic               last_o
);
    localparam logic [VOLT_W-1:0]  V_MAX = {VOLT_W{1'b1}};
    localparam logic [PHASE_W-1:0] P_MAX = {PHASE_W{1'b1}};
    localparam logic [VOLT_W-1:0]  V_ONE = VOLT_W'(1);
    localparam logic [PHASE_W-1:0] P_ONE = PHASE_W'(1);

    logic [PHASE_W-1:0] phase_q;
    logic [VOLT_W-1:0]  volt_q;

    // Advance voltage each step; carry into phase on voltage wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            phase_q <= '0;
            volt_q  <= '0;
        end else if (step_i) begin
            if (volt_q == V_MAX) begin
                volt_q  <= '0;
                phase_q <= phase_q + P_ONE;
            end else begin
                volt_q <= volt_q + V_ONE;
            end
        end
    end

    assign phase_o = phase_q;
    assign volt_o  = volt_q;
    assign last_o  = (phase_q == P_MAX) && (volt_q == V_MAX);
endmodule

// File: rtl/eye_dwell_timer.sv
// Shared down-counter for settle and dwell windows.
// A load sets the remaining-cycle value; afterwards it counts down to zero
// and stops there. zero_o marks the last cycle of the loaded window.
module eye_dwell_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         zero_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    // Load has priority; otherwise decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eye_hit_counter.sv
// Saturating mismatch counter.
// Counts cycles with en_i and hit_i both high and stops at all-ones.
// clear_i wins over counting.
module eye_hit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Accumulate hits inside the window, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (en_i && hit_i && (cnt_q != C_MAX)) begin
            cnt_q <= cnt_q + C_ONE;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/eye_scan_ctrl.sv
// Eye opening monitor sweep controller (top).
// Walks the phase/voltage grid and applies the codes. It discards settle
// cycles, then counts main/offset comparator mismatches over an equal dwell
// per point and emits one result per point on a valid/ready port. Assumes
// the comparator bits are already synchronous to clk.
module eye_scan_ctrl
    import eye_scan_pkg::*;
#(
    parameter int PHASE_W  = 6,
    parameter int VOLT_W   = 6,
    parameter int CNT_W    = 16,
    parameter int DWELL_W  = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_len_i,
    input  logic [DWELL_W-1:0]  dwell_len_i,
    input  logic                main_bit_i,
    input  logic                offs_bit_i,
    output logic [PHASE_W-1:0]  phase_code_o,
    output logic [VOLT_W-1:0]   volt_code_o,
    output logic                res_valid_o,
    input  logic                res_ready_i,
    output logic [PHASE_W-1:0]  res_phase_o,
    output logic [VOLT_W-1:0]   res_volt_o,
    output logic [CNT_W-1:0]    res_hits_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int TMR_W = (DWELL_W > SETTLE_W) ? DWELL_W : SETTLE_W;
    localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

    scan_state_e         state_q, state_d;
    logic [SETTLE_W-1:0] settle_q;
    logic [DWELL_W-1:0]  dwell_q;
    logic                done_q;
    logic                start_ok, handshake, enter_pt, last_pt;
    logic                use_settle, tmr_zero, tmr_load;
    logic [TMR_W-1:0]    settle_ext, dwell_ext, dwell_m1, tmr_val;
    logic [PHASE_W-1:0]  phase_w;
    logic [VOLT_W-1:0]   volt_w;
    logic [CNT_W-1:0]    hits_w;

    // Decode point boundaries and pick live or captured window lengths.
    always_comb begin
        start_ok   = start_i && (state_q == ST_IDLE);
        handshake  = (state_q == ST_EMIT) && res_ready_i;
        enter_pt   = start_ok || (handshake && !last_pt);
        settle_ext = start_ok ? TMR_W'(settle_len_i) : TMR_W'(settle_q);
        dwell_ext  = start_ok ? TMR_W'(dwell_len_i)  : TMR_W'(dwell_q);
        dwell_m1   = (dwell_ext == '0) ? '0 : dwell_ext - TMR_ONE;
        use_settle = (settle_ext != '0);
    end

    // Reload the window timer at point entry and at settle-to-count.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = dwell_m1;
        if (enter_pt) begin
            tmr_load = 1'b1;
            tmr_val  = use_settle ? (settle_ext - TMR_ONE) : dwell_m1;
        end else if ((state_q == ST_SETTLE) && tmr_zero) begin
            tmr_load = 1'b1;
        end
    end

    // Next-state sequencing of one grid point.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = use_settle ? ST_SETTLE : ST_COUNT;
            ST_SETTLE: if (tmr_zero) state_d = ST_COUNT;
            ST_COUNT:  if (tmr_zero) state_d = ST_EMIT;
            ST_EMIT: begin
                if (handshake) begin
                    if (last_pt)         state_d = ST_IDLE;
                    else if (use_settle) state_d = ST_SETTLE;
                    else                 state_d = ST_COUNT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured window lengths and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            settle_q <= '0;
            dwell_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= handshake && last_pt;
            if (start_ok) begin
                settle_q <= settle_len_i;
                dwell_q  <= dwell_len_i;
            end
        end
    end

    eye_grid_stepper #(
        .PHASE_W (PHASE_W),
        .VOLT_W  (VOLT_W)
    ) u_grid (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_ok),
        .step_i  (handshake),
        .phase_o (phase_w),
        .volt_o  (volt_w),
        .last_o  (last_pt)
    );

    eye_dwell_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (tmr_val),
        .zero_o  (tmr_zero)
    );

    eye_hit_counter #(
        .CNT_W (CNT_W)
    ) u_hits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (enter_pt),
        .en_i    (state_q == ST_COUNT),
        .hit_i   (main_bit_i ^ offs_bit_i),
        .count_o (hits_w)
    );

    assign phase_code_o = phase_w;
    assign volt_code_o  = volt_w;
    assign res_phase_o  = phase_w;
    assign res_volt_o   = volt_w;
    assign res_hits_o   = hits_w;
    assign res_valid_o  = (state_q == ST_EMIT);
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
endmodule

// File: rtl/eye_scan_chk.sv
// Protocol checker for eye_scan_ctrl, bound to every instance.
// Observes ports only; all properties are disabled during reset.
module eye_scan_chk #(
    parameter int PHASE_W = 6,
    parameter int VOLT_W  = 6,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [PHASE_W-1:0] phase_code_o,
    input logic [VOLT_W-1:0]  volt_code_o,
    input logic               res_valid_o,
    input logic               res_ready_i,
    input logic [PHASE_W-1:0] res_phase_o,
    input logic [VOLT_W-1:0]  res_volt_o,
    input logic [CNT_W-1:0]   res_hits_o,
    input logic               busy_o,
    input logic               done_o
);
    // R7: a stalled result stays put.
    a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_phase_o)
            && $stable(res_volt_o) && $stable(res_hits_o));

    // R3: codes move only on an accepted result while scanning.
    a_r3_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !(res_valid_o && res_ready_i) |=> $stable(phase_code_o)
            && $stable(volt_code_o));

    // R9: done lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: done is reported only once the scan has ended.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !res_valid_o);

    // R2: a start in idle makes the block busy.
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o);

    // R2: a result only exists inside a scan.
    a_r2_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> busy_o);
endmodule

bind eye_scan_ctrl eye_scan_chk #(
    .PHASE_W (PHASE_W),
    .VOLT_W  (VOLT_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .phase_code_o (phase_code_o),
    .volt_code_o  (volt_code_o),
    .res_valid_o  (res_valid_o),
    .res_ready_i  (res_ready_i),
    .res_phase_o  (res_phase_o),
    .res_volt_o   (res_volt_o),
    .res_hits_o   (res_hits_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/eye_scan_ctrl_tb.sv
// Scoreboard bench: the driver models the front end, tallies expected hits
// and queues expected results; a falling-edge monitor pops and compares.
module eye_scan_ctrl_tb;
    localparam int PW = 6;
    localparam int VW = 6;
    localparam int CW = 16;
    localparam int DW = 16;
    localparam int SW = 8;
    localparam int NPTS = 1 << (PW + VW);
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [SW-1:0] settle_len;
    logic [DW-1:0] dwell_len;
    logic          main_b, offs_b, ready;
    logic [PW-1:0] phase_code, res_phase;
    logic [VW-1:0] volt_code, res_volt;
    logic [CW-1:0] res_hits;
    logic          res_valid, busy, done;

    // Saturation instance: 2 x 2 grid, 4-bit counter.
    logic          s_start;
    logic [0:0]    s_phase, s_volt, s_rphase, s_rvolt;
    logic [3:0]    s_hits;
    logic          s_valid, s_busy, s_done;

    int vec_cnt = 0;
    int err_cnt = 0;
    int wd = 0;
    logic [PW+VW+CW-1:0] exp_q[$];
    bit mon_en = 1'b0;
    bit done_due = 1'b0;
    int mon_idx = 0;

    always #2 clk = ~clk;

    eye_scan_ctrl #(
        .PHASE_W(PW), .VOLT_W(VW), .CNT_W(CW), .DWELL_W(DW), .SETTLE_W(SW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .settle_len_i(settle_len),
        .dwell_len_i(dwell_len), .main_bit_i(main_b), .offs_bit_i(offs_b),
        .phase_code_o(phase_code), .volt_code_o(volt_code),
        .res_valid_o(res_valid), .res_ready_i(ready), .res_phase_o(res_phase),
        .res_volt_o(res_volt), .res_hits_o(res_hits), .busy_o(busy), .done_o(done)
    );

    eye_scan_ctrl #(
        .PHASE_W(1), .VOLT_W(1), .CNT_W(4), .DWELL_W(DW), .SETTLE_W(SW)
    ) u_sat (
        .clk(clk), .rst_n(rst_n), .start_i(s_start), .settle_len_i(8'd0),
        .dwell_len_i(16'd20), .main_bit_i(1'b0), .offs_bit_i(1'b1),
        .phase_code_o(s_phase), .volt_code_o(s_volt),
        .res_valid_o(s_valid), .res_ready_i(1'b1), .res_phase_o(s_rphase),
        .res_volt_o(s_rvolt), .res_hits_o(s_hits), .busy_o(s_busy), .done_o(s_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    endtask

    // Front-end model: forced mismatch while settling and on phase 0, else
    // a position-dependent pattern.
    function automatic bit mis_f(input int p, input int v, input int jn, input int s);
        if (jn <= s) return 1'b1;
        if (p == 0) return 1'b1;
        return ((jn * (v + 1) + p) % 7) < ((v + p) % 8);
    endfunction

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            err_cnt++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below 190000", wd);
            report();
        end
    end

    // Monitor: compare accepted results against the scoreboard and order.
    always @(negedge clk) begin
        if (mon_en) begin
            if (done_due) begin
                chk(done == 1'b1, "R9 done pulse", int'(done), 1);
                chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
                done_due = 1'b0;
            end else begin
                chk(done == 1'b0, "R9 no stray done", int'(done), 0);
            end
            if (res_valid && ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected result", 1, 0);
                end else begin
                    logic [PW+VW+CW-1:0] it;
                    it = exp_q.pop_front();
                    chk(res_hits == it[CW-1:0], "R5 hit count",
                        int'(res_hits), int'(it[CW-1:0]));
                    chk({res_phase, res_volt} == (PW+VW)'(mon_idx), "R3 result order",
                        int'({res_phase, res_volt}), mon_idx);
                    chk({res_phase, res_volt} == it[PW+VW+CW-1:CW], "R3 result tag",
                        int'({res_phase, res_volt}), int'(it[PW+VW+CW-1:CW]));
                end
                mon_idx++;
                if (mon_idx == NPTS) done_due = 1'b1;
            end
        end
    end

    // Driver: one full scan with settle s, dwell d, ready low every rmod-th cycle.
    task automatic run_scan(input int s, input int d, input int rmod);
        int j, pt, tally, cyc, jn, p, v, sat;
        bit hs, m;
        @(posedge clk); #1;
        settle_len = SW'(s);
        dwell_len  = DW'(d);
        start = 1'b1;
        ready = 1'b0;
        mon_idx = 0;
        mon_en = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        // R4: the window lengths were captured; disturb the live inputs.
        settle_len = SW'(s + 3);
        dwell_len  = DW'(d + 2);
        j = 0; pt = 0; tally = 0; cyc = 0;
        while (pt < NPTS) begin
            p = pt >> VW;
            v = pt & ((1 << VW) - 1);
            chk(phase_code == PW'(p), "R3 phase code", int'(phase_code), p);
            chk(volt_code == VW'(v), "R3 volt code", int'(volt_code), v);
            chk(res_valid == (j >= s + d), "R4 valid timing (R10 when settle 0)",
                int'(res_valid), int'(j >= s + d));
            chk(busy == 1'b1, "R2 busy during scan", int'(busy), 1);
            jn = j + 1;
            m = mis_f(p, v, jn, s);
            main_b = 1'((jn + v) & 1);
            offs_b = main_b ^ m;
            if (jn > s && jn <= s + d) tally += int'(m);
            if (jn == s + d) begin
                sat = (tally > CMAX) ? CMAX : tally;
                exp_q.push_back({PW'(p), VW'(v), CW'(sat)});
                tally = 0;
            end
            ready = (rmod == 0) ? 1'b1 : ((cyc % rmod) != rmod - 1);
            start = (pt == 100 && j == 1);  // R8: start while busy
            hs = res_valid && ready;
            @(posedge clk); #1;
            cyc++;
            if (hs) begin
                pt++;
                j = 0;
            end else begin
                j++;
            end
        end
        start = 1'b0;
        ready = 1'b0;
        chk(busy == 1'b0, "R9 busy cleared", int'(busy), 0);
        repeat (3) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
        chk(mon_idx == NPTS, "R3 result count", mon_idx, NPTS);
        mon_en = 1'b0;
    endtask

    // Saturation run on the small instance: 20 mismatches cap at 15.
    task automatic run_sat();
        int n;
        n = 0;
        @(posedge clk); #1;
        s_start = 1'b1;
        @(posedge clk); #1;
        s_start = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (s_valid) begin
                chk(s_hits == 4'd15, "R6 saturated count", int'(s_hits), 15);
                chk({s_rphase, s_rvolt} == 2'(n), "R3 small grid order",
                    int'({s_rphase, s_rvolt}), n);
                n++;
            end
        end
        chk(n == 4, "R6 small grid results", n, 4);
        chk(s_busy == 1'b0, "R9 small grid idle", int'(s_busy), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        s_start = 1'b0;
        settle_len = '0;
        dwell_len = '0;
        main_b = 1'b0;
        offs_b = 1'b0;
        ready = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
        chk(phase_code == '0, "R1 phase code", int'(phase_code), 0);
        chk(volt_code == '0, "R1 volt code", int'(volt_code), 0);
        run_scan(2, 5, 3);
        run_scan(0, 1, 5);   // R10: no settle, single-cycle dwell
        run_sat();
        report();
    end
endmodule